// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a byte-addressed storage space. Its eight highest addresses hold a real-time calendar; every lower address is plain read/write byte storage. Hidden BCD counters keep second, minute, hour (24-hour form), day of week, day of month, month and two-digit year. The counters advance on a single-cycle one-second enable. On that same enable, the counters' new values are copied into eight bus-visible clock bytes. The host reads and writes those bytes with the same port cycles it uses for storage.

The lowest clock address is a control byte. Its two top bits govern host access to the clock bytes. One bit stops the once-per-second copy so that the host can set the time, and clearing it loads the visible bytes into the counters. The other bit freezes the visible copy for a consistent read while the counters keep running. The six low bits hold a calibration value that is only stored and read back.

The address width is a parameter, so the clock bytes always sit at the top of the map. The default is 11 bits, which puts the clock bytes at 0x7F8..0x7FF. A width of 15 gives a 32 KB map with the clock bytes at 0x7FF8..0x7FFF.

Top module: `rtc_mem_top`

## Requirements
- R1: After reset the control byte reads 0x00, and both the counters and the visible bytes hold 00:00:00, day of week 01, date 01, month 01, year 00.
- R2: Addresses below TOP = 2^ADDR_W-8 store bytes. A read with rd_en presents the addressed byte on rdata after the next rising clock edge, and rdata holds that value until the next read.
- R3: The control byte at offset 0 from TOP stores all eight bits written to it. Its bits 5:0 are calibration storage and have no effect on the count rate.
- R4: On each tick_1hz cycle with control bits 7 and 6 clear, the visible bytes take the counters' post-increment values at that same edge. The offsets from TOP are: 1 second, 2 minute, 3 hour, 4 day of week, 5 date, 6 month, 7 year.
- R5: Seconds and minutes wrap 0x59 to 0x00 and carry into the next field. Hours wrap 0x23 to 0x00 and carry into the day. A low BCD digit of 9 rolls to 0 and increments the high digit.
- R6: The day of week advances on each day rollover and wraps from 0x07 to 0x01.
- R7: The date wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February.
- R8: In February the date wraps after 0x29 when the BCD year is divisible by 4, and after 0x28 otherwise.
- R9: The month wraps 0x12 to 0x01 and carries into the year, and the year wraps 0x99 to 0x00.
- R10: While control bit 7 is set, the once-per-second copy stops. A control write that clears bit 7 while it was set loads all seven visible bytes into the counters at that edge.
- R11: While control bit 6 is set, the visible bytes change only by host writes, and the counters keep advancing. The next tick after the bit clears shows the advanced time.
- R12: An invalid BCD value loaded into a counter is not corrected: an increment adds one to its low nibble (0x5A becomes 0x5B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe for wdata at addr |
| rd_en | input | 1 | Read strobe for addr |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A write or a tick takes effect at the edge that samples it. Read data appears on rdata after the edge that samples rd_en. The bench's driver therefore pushes each expected byte as it raises rd_en. The monitor notes at each rising edge whether a read was accepted, and it pops and compares the result at the following falling edge, halfway between edges. Because a read is issued on the cycle after the tick or write it observes, every count, copy, freeze and load result is compared exactly one cycle after its cause.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // Packed calendar; sc occupies bits 7:0, so byte k-1 is clock offset k.
   typedef struct packed {
      logic [7:0] yr;
      logic [7:0] mo;
      logic [7:0] dt;
      logic [7:0] dw;
      logic [7:0] hr;
      logic [7:0] mn;
      logic [7:0] sc;
   } rtc_time_t;

   localparam rtc_time_t TIME_RST = '{yr: 8'h00, mo: 8'h01, dt: 8'h01,
                                      dw: 8'h01, hr: 8'h00, mn: 8'h00, sc: 8'h00};

   localparam int CLK_BYTES = 8;

   // Plain BCD step: no correction of invalid digits.
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      else                return {v[7:4], v[3:0] + 4'h1};
   endfunction

   // Last valid date of a month, in BCD.
   function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
      logic [3:0] m4;
      m4 = yr[3:0] + {yr[6:4], 1'b0};  // 10 is 2 mod 4
      case (mo)
         8'h02:                      return (m4[1:0] == 2'b00) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
   parameter int ADDR_W = 11,
   parameter int DEPTH  = (1 << ADDR_W) - 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        q
);
   if (DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("rtc_byte_store: DEPTH exceeds address space");
   end

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(addr) < DEPTH)) mem[addr] <= wdata;
      if (re) q <= (int'(addr) < DEPTH) ? mem[addr] : 8'h00;
   end
endmodule

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t now,
   output rtc_time_t nxt
);
   logic c_s, c_m, c_h, c_d, c_mo;
   logic [7:0] last_dt;

   always_comb begin
      last_dt = month_last(now.mo, now.yr);
      c_s  = tick && (now.sc == 8'h59);
      c_m  = c_s  && (now.mn == 8'h59);
      c_h  = c_m  && (now.hr == 8'h23);
      c_d  = c_h  && (now.dt == last_dt);
      c_mo = c_d  && (now.mo == 8'h12);

      nxt    = now;
      if (tick) nxt.sc = c_s ? 8'h00 : bcd_inc(now.sc);
      if (c_s)  nxt.mn = c_m ? 8'h00 : bcd_inc(now.mn);
      if (c_m)  nxt.hr = c_h ? 8'h00 : bcd_inc(now.hr);
      if (c_h) begin
         nxt.dw = (now.dw == 8'h07) ? 8'h01 : bcd_inc(now.dw);
         nxt.dt = c_d ? 8'h01 : bcd_inc(now.dt);
      end
      if (c_d)  nxt.mo = c_mo ? 8'h01 : bcd_inc(now.mo);
      if (c_mo) nxt.yr = (now.yr == 8'h99) ? 8'h00 : bcd_inc(now.yr);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    now <= TIME_RST;
      else if (load) now <= load_val;
      else           now <= nxt;
   end

   p_tick_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load) |=> (now.sc != $past(now.sc)));
   p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && now.sc == 8'h59) |=> (now.sc == 8'h00));
   p_hr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && now.hr <= 8'h23) |=> (now.hr <= 8'h23));
   p_dow_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && now.dw >= 8'h01 && now.dw <= 8'h07) |=> (now.dw >= 8'h01 && now.dw <= 8'h07));
   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (now == $past(load_val)));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      wr,
   input  logic      hit,
   input  logic [2:0] idx,
   input  logic [7:0] wdata,
   input  rtc_time_t cnt_nxt,
   output logic [7:0] ctrl,
   output rtc_time_t vis,
   output logic      load
);
   logic [55:0] nxt_flat;
   logic [55:0] vis_flat;
   logic        upd;
   logic        hwr;

   assign nxt_flat = cnt_nxt;
   assign vis      = vis_flat;
   assign hwr      = wr && hit;
   assign upd      = tick && !ctrl[7] && !ctrl[6];
   assign load     = hwr && (idx == 3'd0) && ctrl[7] && !wdata[7];

   always_ff @(posedge clk) begin
      if (!rst_n)                      ctrl <= 8'h00;
      else if (hwr && idx == 3'd0)     ctrl <= wdata;
   end

   for (genvar i = 1; i < CLK_BYTES; i++) begin : g_byte
      localparam logic [55:0] RST_FLAT = TIME_RST;
      always_ff @(posedge clk) begin
         if (!rst_n)                          vis_flat[(i-1)*8 +: 8] <= RST_FLAT[(i-1)*8 +: 8];
         else if (hwr && idx == 3'(i))        vis_flat[(i-1)*8 +: 8] <= wdata;
         else if (upd)                        vis_flat[(i-1)*8 +: 8] <= nxt_flat[(i-1)*8 +: 8];
      end
   end

   p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[6] && !hwr) |=> $stable(vis_flat));
   p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[7] && !hwr) |=> $stable(vis_flat));
endmodule

// File: rtl/rtc_mem_top.sv
module rtc_mem_top
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int STORE_DEPTH = (1 << ADDR_W) - CLK_BYTES;

   if (ADDR_W < 4 || ADDR_W > 15) begin : g_bad_aw
      $error("rtc_mem_top: ADDR_W must be 4..15");
   end

   logic       hit, hit_q;
   logic [2:0] idx;
   logic [7:0] ctrl, clk_q, ram_q;
   logic       load;
   rtc_time_t  now, nxt, vis;
   logic [55:0] vis_flat;

   assign hit      = &addr[ADDR_W-1:3];
   assign idx      = addr[2:0];
   assign vis_flat = vis;

   rtc_byte_store #(.ADDR_W(ADDR_W), .DEPTH(STORE_DEPTH)) u_store (
      .clk(clk), .we(wr_en && !hit), .re(rd_en && !hit),
      .addr(addr), .wdata(wdata), .q(ram_q));

   rtc_bcd_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .load(load),
      .load_val(vis), .now(now), .nxt(nxt));

   rtc_regfile u_regs (
      .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr(wr_en), .hit(hit),
      .idx(idx), .wdata(wdata), .cnt_nxt(nxt), .ctrl(ctrl), .vis(vis), .load(load));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         clk_q <= 8'h00;
      end else if (rd_en) begin
         hit_q <= hit;
         clk_q <= (idx == 3'd0) ? ctrl : vis_flat[(int'(idx)-1)*8 +: 8];
      end
   end

   assign rdata = hit_q ? clk_q : ram_q;

   p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && hit && idx == 3'd0) |=> $stable(ctrl));
endmodule

// File: tb/rtc_mem_top_tb.sv
module rtc_mem_top_tb;
   localparam int AW = 11;
   localparam logic [AW-1:0] TOP = 11'h7F8;

   logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0] wdata = 8'h00, rdata;
   int checks = 0, errors = 0, cycles = 0;
   logic pend = 1'b0;
   logic [7:0] exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   rtc_mem_top #(.ADDR_W(AW)) u_dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
      .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata));

   // monitor
   always @(posedge clk) pend <= rd_en && rst_n;
   always @(negedge clk) begin
      if (pend) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rdata !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, rdata, e);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tick();
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] s, mn, h, dw, dt, mo, yr);
      wr(TOP, 8'h80);
      wr(TOP + 1, s);  wr(TOP + 2, mn); wr(TOP + 3, h);
      wr(TOP + 4, dw); wr(TOP + 5, dt); wr(TOP + 6, mo); wr(TOP + 7, yr);
      wr(TOP, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(TOP, 8'h00, "R1 ctrl");
      rd(TOP + 1, 8'h00, "R1 sec");
      rd(TOP + 3, 8'h00, "R1 hour");
      rd(TOP + 4, 8'h01, "R1 dow");
      rd(TOP + 5, 8'h01, "R1 date");
      rd(TOP + 6, 8'h01, "R1 month");
      rd(TOP + 7, 8'h00, "R1 year");
      // R2 storage
      wr(11'h000, 8'hA5); wr(11'h7F7, 8'h3C); wr(11'h155, 8'h0F);
      rd(11'h000, 8'hA5, "R2 low");
      rd(11'h7F7, 8'h3C, "R2 top store");
      rd(11'h155, 8'h0F, "R2 mid");
      // R3 calibration bits stored, R4 copy on tick
      wr(TOP, 8'h2A);
      rd(TOP, 8'h2A, "R3 ctrl readback");
      tick();
      rd(TOP + 1, 8'h01, "R3 R4 sec after tick");
      wr(TOP, 8'h00);
      // R5 R6 R8 cascade, non-leap February
      set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
      rd(TOP + 5, 8'h28, "R10 loaded date");
      tick();
      rd(TOP + 1, 8'h59, "R5 sec 59");
      tick();
      rd(TOP + 1, 8'h00, "R5 sec wrap");
      rd(TOP + 2, 8'h00, "R5 min wrap");
      rd(TOP + 3, 8'h00, "R5 hour wrap");
      rd(TOP + 4, 8'h01, "R6 dow wrap");
      rd(TOP + 5, 8'h01, "R8 date nonleap");
      rd(TOP + 6, 8'h03, "R8 month nonleap");
      rd(TOP + 7, 8'h23, "R9 year held");
      // R8 leap year
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
      tick();
      rd(TOP + 5, 8'h29, "R8 leap date 29");
      rd(TOP + 4, 8'h04, "R6 dow step");
      set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
      tick();
      rd(TOP + 5, 8'h01, "R8 leap date wrap");
      rd(TOP + 6, 8'h03, "R8 leap month");
      // R7 30- and 31-day months
      set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
      tick();
      rd(TOP + 5, 8'h01, "R7 april wrap");
      rd(TOP + 6, 8'h05, "R7 may");
      set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h10);
      tick();
      rd(TOP + 5, 8'h31, "R7 may 31");
      // R9 year rollover
      set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
      tick();
      rd(TOP + 5, 8'h01, "R9 date");
      rd(TOP + 6, 8'h01, "R9 month");
      rd(TOP + 7, 8'h00, "R9 year");
      // R11 read freeze
      set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01);
      wr(TOP, 8'h40);
      tick(); tick();
      rd(TOP + 1, 8'h10, "R11 frozen");
      wr(TOP, 8'h00);
      tick();
      rd(TOP + 1, 8'h13, "R11 counters ran");
      // R10 write halt and load
      wr(TOP, 8'h80);
      tick();
      rd(TOP + 1, 8'h13, "R10 copy halted");
      wr(TOP + 1, 8'h45);
      wr(TOP, 8'h00);
      rd(TOP + 1, 8'h45, "R10 visible after load");
      tick();
      rd(TOP + 1, 8'h46, "R10 counter loaded");
      // R12 invalid digit, R5 digit carry
      set_time(8'h5A, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01);
      tick();
      rd(TOP + 1, 8'h5B, "R12 invalid step");
      rd(TOP + 2, 8'h00, "R12 no carry");
      set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01);
      tick();
      rd(TOP + 1, 8'h10, "R5 digit carry");
      rd(11'h000, 8'hA5, "R2 storage kept");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule